// File: doc/BRIEF.md
# PTP System Time Counter

This block keeps the time of day for precision time protocol use. The time is a seconds count plus a 31-bit sub-second field. A 32-bit accumulator adds a programmable addend on every clock. Each carry out of that accumulator is one increment event, and each event adds a programmable sub-second step to the time. Software sets the effective rate by choosing the addend and the step. It then trims the rate by loading a new addend, without ever stopping the count.

The sub-second field wraps in one of two ways. In decimal mode it counts nanoseconds and wraps after 999,999,999. In binary mode it wraps after 2^31 - 1. Software can overwrite the time outright, or add or subtract a signed offset that carries or borrows between the two fields. It can also arm a one-shot alarm, which fires when the time moves past a target value. Every command is a one-cycle pulse. It raises a busy flag, and that flag drops in the cycle the new value becomes visible.

Top module: `ptp_clock_core`

## Requirements
- R1: With `roll_digital` = 1, an increment that takes the sub-second field above 0x3B9A_C9FF subtracts 0x3B9A_CA00 from it and adds one to the seconds.
- R2: With `roll_digital` = 0, an increment that takes the sub-second field above 0x7FFF_FFFF subtracts 0x8000_0000 from it and adds one to the seconds.
- R3: Every clock the accumulator adds the active addend. A carry out of bit 31 adds `sub_inc` to the time at that same edge. Without a carry the time holds.
- R4: An `cmd_addend_ld` pulse latches `addend_in` and sets `addend_busy` for exactly one cycle. The new addend is active from the edge that clears the flag. A pulse that arrives while the flag is set is ignored.
- R5: An `cmd_init` pulse sets `init_busy` for one cycle. At the edge that clears the flag, the time becomes `upd_sec` and `upd_sub[30:0]`. Bit 31 of `upd_sub` is ignored.
- R6: An `cmd_update` pulse sets `upd_busy` for one cycle. At the edge that clears the flag, the offset is applied. If `upd_sub[31]` = 0, the offset `upd_sec`/`upd_sub[30:0]` is added; if it is 1, the offset is subtracted. A carry or borrow between the two fields uses the active wrap limit.
- R7: While either `init_busy` or `upd_busy` is set, further init and update pulses are ignored. If both pulses arrive in one cycle, only the init is taken. An increment event that falls in a command's completion cycle is dropped.
- R8: A `cmd_arm` pulse sets `arm_en`. While `arm_en` is set and the time is strictly greater than the target, comparing seconds first and then sub-seconds, `irq` is high in the next cycle and `arm_en` clears at that same edge. A time equal to the target does not fire.
- R9: After reset the time, the accumulator, the addend and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| roll_digital | input | 1 | 1: decimal nanosecond wrap, 0: binary wrap |
| cmd_addend_ld | input | 1 | Pulse: load a new addend |
| addend_in | input | ACC_W | Addend value to load |
| sub_inc | input | INC_W | Sub-second step per increment event |
| cmd_init | input | 1 | Pulse: overwrite the time |
| cmd_update | input | 1 | Pulse: add or subtract the offset |
| upd_sec | input | SEC_W | Seconds value for init or update |
| upd_sub | input | 32 | Bit 31 is the sign (1 = subtract), bits 30:0 are sub-seconds |
| cmd_arm | input | 1 | Pulse: arm the target alarm |
| tgt_sec | input | SEC_W | Target seconds |
| tgt_sub | input | 31 | Target sub-seconds |
| time_sec | output | SEC_W | Current seconds |
| time_sub | output | 31 | Current sub-seconds |
| addend_busy | output | 1 | Addend load in progress |
| init_busy | output | 1 | Init in progress |
| upd_busy | output | 1 | Offset update in progress |
| arm_en | output | 1 | Alarm armed |
| irq | output | 1 | Alarm fired (one cycle per firing) |

## Verification
A wrong accumulator or addend state shows up as a different tick rate. It appears at `time_sub` within one addend period after the faulty cycle, and the cycle-by-cycle comparison catches it there. A wrong carry, borrow or wrap limit appears at `time_sec` and `time_sub` in the first cycle after the wrap or the offset is applied. The bench forces that case at both wrap limits, for sub-second values next to zero and next to the limit. A stuck busy flag or a lost alarm shows within one or two cycles of the pulse.

// File: rtl/ptp_clk_pkg.sv
package ptp_clk_pkg;
   localparam int SUB_W = 31;
   localparam logic [31:0] WRAP_DEC = 32'h3B9A_C9FF;
   localparam logic [31:0] WRAP_BIN = 32'h7FFF_FFFF;

   function automatic logic [31:0] wrap_limit(input logic digital);
      return digital ? WRAP_DEC : WRAP_BIN;
   endfunction
endpackage

// File: rtl/ptp_rate_acc.sv
module ptp_rate_acc #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_load,
   input  logic [ACC_W-1:0] addend_in,
   output logic             tick,
   output logic             load_busy
);
   if (ACC_W < 8) begin : g_bad_acc_w
      $error("ptp_rate_acc: ACC_W must be at least 8");
   end

   logic [ACC_W-1:0] acc_q, addend_q, pend_q;
   logic [ACC_W:0]   sum;

   assign sum  = {1'b0, acc_q} + {1'b0, addend_q};
   assign tick = sum[ACC_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q     <= '0;
         addend_q  <= '0;
         pend_q    <= '0;
         load_busy <= 1'b0;
      end else begin
         acc_q <= sum[ACC_W-1:0];
         if (load_busy) begin
            addend_q  <= pend_q;
            load_busy <= 1'b0;
         end else if (cmd_load) begin
            pend_q    <= addend_in;
            load_busy <= 1'b1;
         end
      end
   end

   a_r4_addend_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
      load_busy |=> !load_busy);
endmodule

// File: rtl/ptp_time_keeper.sv
module ptp_time_keeper
   import ptp_clk_pkg::*;
#(
   parameter int SEC_W = 32,
   parameter int INC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             digital,
   input  logic             tick,
   input  logic [INC_W-1:0] sub_inc,
   input  logic             cmd_init,
   input  logic             cmd_update,
   input  logic [SEC_W-1:0] upd_sec,
   input  logic [31:0]      upd_sub,
   output logic [SEC_W-1:0] time_sec,
   output logic [SUB_W-1:0] time_sub,
   output logic             init_busy,
   output logic             upd_busy
);
   if (INC_W < 1 || INC_W > 30) begin : g_bad_inc_w
      $error("ptp_time_keeper: INC_W must lie in 1..30");
   end
   if (SEC_W < 2) begin : g_bad_sec_w
      $error("ptp_time_keeper: SEC_W must be at least 2");
   end

   localparam logic [SEC_W-1:0] SEC_ONE = SEC_W'(1);

   logic [SEC_W-1:0] sh_sec;
   logic [31:0]      sh_sub;
   logic             idle;
   logic [31:0]      lim, span, now, mag, t_tick, t_adj;
   logic [SEC_W-1:0] sec_tick, sec_adj;

   assign idle = !init_busy && !upd_busy;
   assign lim  = wrap_limit(digital);
   assign span = lim + 32'd1;
   assign now  = {1'b0, time_sub};
   assign mag  = {1'b0, sh_sub[SUB_W-1:0]};

   always_comb begin
      t_tick   = now + 32'(sub_inc);
      sec_tick = time_sec;
      if (t_tick > lim) begin
         t_tick   = t_tick - span;
         sec_tick = time_sec + SEC_ONE;
      end
      if (!sh_sub[31]) begin
         t_adj   = now + mag;
         sec_adj = time_sec + sh_sec;
         if (t_adj > lim) begin
            t_adj   = t_adj - span;
            sec_adj = sec_adj + SEC_ONE;
         end
      end else if (now >= mag) begin
         t_adj   = now - mag;
         sec_adj = time_sec - sh_sec;
      end else begin
         t_adj   = now + span - mag;
         sec_adj = time_sec - sh_sec - SEC_ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         time_sec  <= '0;
         time_sub  <= '0;
         sh_sec    <= '0;
         sh_sub    <= '0;
         init_busy <= 1'b0;
         upd_busy  <= 1'b0;
      end else begin
         if (idle && cmd_init) begin
            init_busy <= 1'b1;
            sh_sec    <= upd_sec;
            sh_sub    <= upd_sub;
         end else if (idle && cmd_update) begin
            upd_busy <= 1'b1;
            sh_sec   <= upd_sec;
            sh_sub   <= upd_sub;
         end
         if (init_busy) begin
            time_sec  <= sh_sec;
            time_sub  <= sh_sub[SUB_W-1:0];
            init_busy <= 1'b0;
         end else if (upd_busy) begin
            time_sec <= sec_adj;
            time_sub <= t_adj[SUB_W-1:0];
            upd_busy <= 1'b0;
         end else if (tick) begin
            time_sec <= sec_tick;
            time_sub <= t_tick[SUB_W-1:0];
         end
      end
   end

   a_r5_init_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
      init_busy |=> !init_busy);
   a_r6_upd_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
      upd_busy |=> !upd_busy);
   a_r7_one_pending: assert property (@(posedge clk) disable iff (!rst_n)
      !(init_busy && upd_busy));
   a_r3_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(init_busy || upd_busy) |->
         (time_sec == $past(time_sec) || time_sec == $past(time_sec) + SEC_ONE));
   a_r1_dec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (digital && $past(digital) && !$past(init_busy || upd_busy)
       && ({1'b0, $past(time_sub)} <= WRAP_DEC)) |-> ({1'b0, time_sub} <= WRAP_DEC));
endmodule

// File: rtl/ptp_target_alarm.sv
module ptp_target_alarm #(
   parameter int SEC_W = 32,
   parameter int SUB_W = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_arm,
   input  logic [SEC_W-1:0] time_sec,
   input  logic [SUB_W-1:0] time_sub,
   input  logic [SEC_W-1:0] tgt_sec,
   input  logic [SUB_W-1:0] tgt_sub,
   output logic             arm_en,
   output logic             irq
);
   logic passed;

   assign passed = (time_sec > tgt_sec) || ((time_sec == tgt_sec) && (time_sub > tgt_sub));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_en <= 1'b0;
         irq    <= 1'b0;
      end else begin
         irq <= arm_en && passed;
         if (arm_en && passed) arm_en <= 1'b0;
         else if (cmd_arm)     arm_en <= 1'b1;
      end
   end

   a_r8_fire_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (!arm_en && $past(arm_en)));
endmodule

// File: rtl/ptp_clock_core.sv
module ptp_clock_core
   import ptp_clk_pkg::*;
#(
   parameter int SEC_W = 32,
   parameter int ACC_W = 32,
   parameter int INC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             roll_digital,
   input  logic             cmd_addend_ld,
   input  logic [ACC_W-1:0] addend_in,
   input  logic [INC_W-1:0] sub_inc,
   input  logic             cmd_init,
   input  logic             cmd_update,
   input  logic [SEC_W-1:0] upd_sec,
   input  logic [31:0]      upd_sub,
   input  logic             cmd_arm,
   input  logic [SEC_W-1:0] tgt_sec,
   input  logic [30:0]      tgt_sub,
   output logic [SEC_W-1:0] time_sec,
   output logic [30:0]      time_sub,
   output logic             addend_busy,
   output logic             init_busy,
   output logic             upd_busy,
   output logic             arm_en,
   output logic             irq
);
   logic tick;

   ptp_rate_acc #(.ACC_W(ACC_W)) u_rate (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_load  (cmd_addend_ld),
      .addend_in (addend_in),
      .tick      (tick),
      .load_busy (addend_busy)
   );

   ptp_time_keeper #(.SEC_W(SEC_W), .INC_W(INC_W)) u_time (
      .clk        (clk),
      .rst_n      (rst_n),
      .digital    (roll_digital),
      .tick       (tick),
      .sub_inc    (sub_inc),
      .cmd_init   (cmd_init),
      .cmd_update (cmd_update),
      .upd_sec    (upd_sec),
      .upd_sub    (upd_sub),
      .time_sec   (time_sec),
      .time_sub   (time_sub),
      .init_busy  (init_busy),
      .upd_busy   (upd_busy)
   );

   ptp_target_alarm #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_alarm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_arm  (cmd_arm),
      .time_sec (time_sec),
      .time_sub (time_sub),
      .tgt_sec  (tgt_sec),
      .tgt_sub  (tgt_sub),
      .arm_en   (arm_en),
      .irq      (irq)
   );
endmodule

// File: tb/ptp_clock_core_tb_top.sv
module ptp_clock_core_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] LIM_D = 32'h3B9A_C9FF;
   localparam logic [31:0] LIM_B = 32'h7FFF_FFFF;

   logic clk = 1'b0, rst_n = 1'b0;
   logic roll_digital = 1'b0, cmd_addend_ld = 1'b0, cmd_init = 1'b0, cmd_update = 1'b0, cmd_arm = 1'b0;
   logic [31:0] addend_in = '0, upd_sec = '0, upd_sub = '0, tgt_sec = '0;
   logic [7:0]  sub_inc = '0;
   logic [30:0] tgt_sub = '0;
   logic [31:0] time_sec;
   logic [30:0] time_sub;
   logic addend_busy, init_busy, upd_busy, arm_en, irq;

   int n_cmp = 0, n_bad = 0;
   logic lockstep = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ptp_clock_core dut_i (
      .clk(clk), .rst_n(rst_n), .roll_digital(roll_digital), .cmd_addend_ld(cmd_addend_ld),
      .addend_in(addend_in), .sub_inc(sub_inc), .cmd_init(cmd_init), .cmd_update(cmd_update),
      .upd_sec(upd_sec), .upd_sub(upd_sub), .cmd_arm(cmd_arm), .tgt_sec(tgt_sec), .tgt_sub(tgt_sub),
      .time_sec(time_sec), .time_sub(time_sub), .addend_busy(addend_busy), .init_busy(init_busy),
      .upd_busy(upd_busy), .arm_en(arm_en), .irq(irq));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Arithmetic of the requirements: offset or step applied with wrap limit lim.
   function automatic void f_apply(input logic [31:0] sec, input logic [30:0] sub,
                                   input logic [31:0] dsec, input logic [31:0] dsub,
                                   input logic [31:0] lim,
                                   output logic [31:0] nsec, output logic [30:0] nsub);
      logic [31:0] n, m, t, span;
      n = {1'b0, sub};
      m = {1'b0, dsub[30:0]};
      span = lim + 32'd1;
      if (!dsub[31]) begin
         t = n + m;
         nsec = sec + dsec;
         if (t > lim) begin t = t - span; nsec = nsec + 1; end
      end else if (n >= m) begin
         t = n - m; nsec = sec - dsec;
      end else begin
         t = n + span - m; nsec = sec - dsec - 1;
      end
      nsub = t[30:0];
   endfunction

   // Cycle model built from the requirements.
   logic [31:0] m_acc, m_add, m_pend, m_sec, m_shsec, m_shsub;
   logic [30:0] m_sub;
   logic m_ab, m_ib, m_ub, m_arm, m_irq;

   always @(posedge clk) begin : model
      logic [32:0] s;
      logic idle, gt;
      logic [31:0] lim, ns;
      logic [30:0] nb;
      if (!rst_n) begin
         m_acc = 0; m_add = 0; m_pend = 0; m_sec = 0; m_shsec = 0; m_shsub = 0;
         m_sub = 0; m_ab = 0; m_ib = 0; m_ub = 0; m_arm = 0; m_irq = 0;
      end else begin
         s = {1'b0, m_acc} + {1'b0, m_add};
         lim = roll_digital ? LIM_D : LIM_B;
         idle = !m_ib && !m_ub;
         gt = (m_sec > tgt_sec) || (m_sec == tgt_sec && m_sub > tgt_sub);
         m_irq = m_arm && gt;
         if (m_arm && gt) m_arm = 0; else if (cmd_arm) m_arm = 1;
         if (m_ib) begin
            m_sec = m_shsec; m_sub = m_shsub[30:0]; m_ib = 0;
         end else if (m_ub) begin
            f_apply(m_sec, m_sub, m_shsec, m_shsub, lim, ns, nb);
            m_sec = ns; m_sub = nb; m_ub = 0;
         end else if (s[32]) begin
            f_apply(m_sec, m_sub, 0, {24'd0, sub_inc}, lim, ns, nb);
            m_sec = ns; m_sub = nb;
         end
         if (idle && cmd_init) begin
            m_ib = 1; m_shsec = upd_sec; m_shsub = upd_sub;
         end else if (idle && cmd_update) begin
            m_ub = 1; m_shsec = upd_sec; m_shsub = upd_sub;
         end
         m_acc = s[31:0];
         if (m_ab) begin m_add = m_pend; m_ab = 0; end
         else if (cmd_addend_ld) begin m_pend = addend_in; m_ab = 1; end
      end
   end

   always @(negedge clk) begin
      if (rst_n && lockstep) begin
         chk("R3 time_sec", time_sec, m_sec);
         chk("R3 time_sub", time_sub, m_sub);
         chk("R4 addend_busy", addend_busy, m_ab);
         chk("R5 init_busy", init_busy, m_ib);
         chk("R6 upd_busy", upd_busy, m_ub);
         chk("R8 arm_en", arm_en, m_arm);
         chk("R8 irq", irq, m_irq);
      end
   end

   task automatic ld_addend(input logic [31:0] a);
      @(negedge clk); addend_in = a; cmd_addend_ld = 1;
      @(negedge clk); cmd_addend_ld = 0;
      @(negedge clk);
   endtask

   task automatic do_init(input logic [31:0] s, input logic [31:0] b);
      @(negedge clk); upd_sec = s; upd_sub = b; cmd_init = 1;
      @(negedge clk); cmd_init = 0;
      @(negedge clk);
   endtask

   task automatic do_update(input logic [31:0] s, input logic [31:0] b);
      @(negedge clk); upd_sec = s; upd_sub = b; cmd_update = 1;
      @(negedge clk); cmd_update = 0;
      @(negedge clk);
   endtask

   task automatic wrap_case(input logic dig, input string tag);
      logic [31:0] lim, start;
      int guard;
      lim = dig ? LIM_D : LIM_B;
      ld_addend(32'h0);
      @(negedge clk); roll_digital = dig; sub_inc = 8'd100;
      do_init(32'd7, lim - 32'd50);
      ld_addend(32'h8000_0000);
      start = time_sec;
      guard = 0;
      while (time_sec == start && guard < 20) begin @(negedge clk); guard++; end
      chk({tag, " wrap sec"}, time_sec, start + 1);
      chk({tag, " wrap sub"}, time_sub, 31'd49);
   endtask

   initial begin : main
      logic [31:0] lim, es, ssub, mag;
      logic [30:0] eb;
      int guard;
      logic seen;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 time_sec", time_sec, 0);
      chk("R9 time_sub", time_sub, 0);
      chk("R9 flags", {addend_busy, init_busy, upd_busy, arm_en, irq}, 0);
      rst_n = 1;
      lockstep = 1;
      repeat (3) @(negedge clk);
      chk("R3 no addend holds time", {time_sec, 1'b0, time_sub}, 0);

      // R4: busy for one cycle, second pulse while busy is ignored
      @(negedge clk); addend_in = 32'h4000_0000; cmd_addend_ld = 1; sub_inc = 8'd3;
      @(negedge clk); addend_in = 32'hFFFF_FFFF;
      chk("R4 busy after pulse", addend_busy, 1);
      @(negedge clk); cmd_addend_ld = 0;
      chk("R4 busy cleared", addend_busy, 0);
      repeat (16) @(negedge clk);
      chk("R4 ignored pulse kept rate 1/4", time_sub, 31'd12);

      // R2 and R1 wrap points
      wrap_case(1'b0, "R2");
      wrap_case(1'b1, "R1");
      repeat (40) @(negedge clk);

      // R6: offset sweep across both limits, boundary values and signs
      ld_addend(32'h0);
      for (int md = 0; md < 2; md++) begin
         @(negedge clk); roll_digital = md[0];
         lim = md[0] ? LIM_D : LIM_B;
         for (int si = 0; si < 4; si++) begin
            for (int mi = 0; mi < 3; mi++) begin
               for (int sg = 0; sg < 2; sg++) begin
                  ssub = (si == 0) ? 0 : (si == 1) ? 1 : (si == 2) ? lim - 1 : lim;
                  mag  = (mi == 0) ? 0 : (mi == 1) ? 1 : lim;
                  do_init(32'd10, {1'b1, ssub[30:0]});
                  chk("R5 init ignores sign bit", {time_sec, 1'b0, time_sub}, {32'd10, 1'b0, ssub[30:0]});
                  do_update(32'd3, {sg[0], mag[30:0]});
                  f_apply(32'd10, ssub[30:0], 32'd3, {sg[0], mag[30:0]}, lim, es, eb);
                  chk("R6 offset sec", time_sec, es);
                  chk("R6 offset sub", time_sub, eb);
               end
            end
         end
      end

      // R7: simultaneous pulses, and update pulse while init busy
      @(negedge clk); upd_sec = 32'd44; upd_sub = 32'd5; cmd_init = 1; cmd_update = 1;
      @(negedge clk); cmd_init = 0; cmd_update = 1;
      @(negedge clk); cmd_update = 0;
      chk("R7 init wins sec", time_sec, 32'd44);
      chk("R7 init wins sub", time_sub, 31'd5);
      chk("R7 no update pending", upd_busy, 0);
      ld_addend(32'hFFFF_FFFF);
      do_update(32'd1, 32'd2);
      repeat (10) @(negedge clk);

      // R8: equal time does not fire
      ld_addend(32'h0);
      do_init(32'd20, 32'd3);
      @(negedge clk); tgt_sec = 32'd20; tgt_sub = 31'd3; cmd_arm = 1;
      @(negedge clk); cmd_arm = 0;
      repeat (8) @(negedge clk);
      chk("R8 equal no irq", irq, 0);
      chk("R8 equal stays armed", arm_en, 1);
      // R8: passing the target fires once and disarms
      @(negedge clk); sub_inc = 8'd1;
      ld_addend(32'h8000_0000);
      seen = 0; guard = 0;
      while (!seen && guard < 40) begin
         @(negedge clk); guard++;
         if (irq) seen = 1;
      end
      chk("R8 irq seen", seen, 1);
      chk("R8 time past target", (time_sec == 20 && time_sub > 3) || time_sec > 20, 1);
      chk("R8 disarmed", arm_en, 0);
      @(negedge clk);
      chk("R8 single pulse", irq, 0);
      repeat (20) @(negedge clk);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule